// File: doc/BRIEF.md
# Per-Block Character Occurrence Counter

This block watches a serial stream that carries 8-bit characters, one bit per clock, most significant bit first. It counts how many characters in each run of 256 characters equal the ASCII at-sign (0x40). Character framing is not signalled. After reset a free-running bit-phase counter treats the first bit as the start of a character and every eighth bit as its end.

At the end of the last bit of each character, the eight most recent bits are compared with the target code. A character counter advances at every character end and wraps after 256 characters. When the 256th character of a block ends, the block's tally is copied to the output. That tally includes the final character if it matches. A one-cycle done strobe is raised with it, and the internal tally restarts from zero for the next block. The output count is 9 bits wide so that a block in which every character matches can report 256.

Top module: `char_tally`

## Requirements
- R1: While reset is asserted and after it is released, block_count is 0 and block_done is 0. The first bit sampled after release is the most significant bit of character 0.
- R2: Bits are taken most significant first, and each group of eight consecutive bits after reset forms one character.
- R3: A character counts only when all eight of its aligned bits equal 0x40. Other codes do not count. A 0x40 bit pattern that straddles two characters does not count.
- R4: block_done is high for exactly one cycle, on the cycle after the clock edge that samples the last bit of every 256th character, which is every 2048 cycles.
- R5: On block_done, block_count equals the number of matching characters in that block, including the 256th character, up to a maximum of 256.
- R6: The tally restarts at every block, so matches from one block never add to the next block's count.
- R7: block_count changes only in the cycle in which block_done is high, and it holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock, one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Serial data bit |
| block_count | output | 9 | Matching-character count of the last completed block |
| block_done | output | 1 | One-cycle strobe when a block completes |

## Verification
In one cycle the block can need to add a match on the 256th character and also copy out and clear the tally for the block. The bench provokes this with a block made entirely of at-signs, which must report 256. It follows that with a block whose first and last characters are the only at-signs, which must report 2 and not carry anything from the previous block. A mid-block reset must then realign the framing, so that the next full block is counted from its first bit.

// File: rtl/char_tally.sv
module char_tally #(
  parameter int CHAR_W = 8,
  parameter int BLOCK_LEN = 256,
  parameter logic [CHAR_W-1:0] TARGET = 8'h40,
  localparam int PH_W = $clog2(CHAR_W),
  localparam int IDX_W = $clog2(BLOCK_LEN),
  localparam int CNT_W = $clog2(BLOCK_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  output logic [CNT_W-1:0] block_count,
  output logic             block_done
);
  localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(CHAR_W - 1);
  localparam logic [IDX_W-1:0] LAST_CHR = IDX_W'(BLOCK_LEN - 1);

  logic [PH_W-1:0]   phase;
  logic [CHAR_W-2:0] hist;
  logic [IDX_W-1:0]  chr;
  logic [CNT_W-1:0]  tally;

  wire               last_bit = (phase == LAST_PH);
  wire [CHAR_W-1:0]  win      = {hist, bit_in};
  wire               hit      = last_bit && (win == TARGET);
  wire               blk_end  = last_bit && (chr == LAST_CHR);
  wire [CNT_W-1:0]   tally_nx = tally + CNT_W'(hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= '0;
      hist        <= '0;
      chr         <= '0;
      tally       <= '0;
      block_count <= '0;
      block_done  <= 1'b0;
    end else begin
      hist       <= win[CHAR_W-2:0];
      phase      <= last_bit ? '0 : phase + 1'b1;
      block_done <= blk_end;
      if (last_bit) chr <= blk_end ? '0 : chr + 1'b1;
      if (blk_end) begin
        block_count <= tally_nx;
        tally       <= '0;
      end else begin
        tally <= tally_nx;
      end
    end
  end
endmodule

module char_tally_chk #(
  parameter int CHAR_W = 8,
  parameter int BLOCK_LEN = 256,
  localparam int CNT_W = $clog2(BLOCK_LEN + 1),
  localparam int GAP_W = $clog2(BLOCK_LEN * CHAR_W + 1) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] block_count,
  input logic             block_done
);
  localparam logic [GAP_W-1:0] PERIOD = GAP_W'(BLOCK_LEN * CHAR_W);
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= '0;
    else        gap <= block_done ? GAP_W'(1) : gap + 1'b1;
  end

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |=> !block_done);
  p_done_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |-> (gap == PERIOD));
  p_done_due_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gap == PERIOD) |-> block_done);
  p_count_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    block_count <= CNT_W'(BLOCK_LEN));
  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !block_done |-> $stable(block_count));
endmodule

bind char_tally char_tally_chk #(.CHAR_W(CHAR_W), .BLOCK_LEN(BLOCK_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .block_count(block_count), .block_done(block_done)
);

// File: tb/char_tally_tb.sv
`timescale 1ns/1ps
module char_tally_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0;
  logic [8:0] block_count;
  logic block_done;

  int tests = 0;
  int fails = 0;
  int sent = 0;
  int tally_m = 0;
  int exp_count = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  char_tally u_dut (.clk(clk), .rst_n(rst_n), .bit_in(bit_in),
                    .block_count(block_count), .block_done(block_done));

  function automatic bit is_target(input logic [7:0] c);
    return c == 8'h40;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] c);
    if (is_target(c)) tally_m++;
    sent++;
    for (int i = 7; i >= 0; i--) begin
      bit_in = c[i];
      @(negedge clk);
      if (i == 0 && sent % 256 == 0) begin
        exp_count = tally_m;
        tally_m = 0;
        check(block_done == 1'b1, "R4 done strobe", block_done, 1);
        check(block_count == 9'(exp_count), "R5 R6 block count", block_count, exp_count);
      end else begin
        check(block_done == 1'b0, "R4 no stray strobe", block_done, 0);
        if (i == 0)
          check(block_count == 9'(exp_count), "R7 count held", block_count, exp_count);
      end
    end
  endtask

  function automatic logic [7:0] rand_char(input int pct);
    logic [7:0] c;
    if (int'($urandom_range(99)) < pct) return 8'h40;
    c = 8'($urandom);
    if (c == 8'h40) c = 8'h41;
    return c;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(block_count == 9'd0 && block_done == 1'b0, "R1 reset state", block_count, 0);
    rst_n = 1'b1;
    // R5: every character matches, including the 256th
    for (int k = 0; k < 256; k++) send_char(8'h40);
    // R3: near misses and random non-target codes
    for (int k = 0; k < 256; k++) begin
      case (k % 6)
        0: send_char(8'h41);
        1: send_char(8'hC0);
        2: send_char(8'h20);
        3: send_char(8'h80);
        4: send_char(8'h00);
        default: send_char(rand_char(0));
      endcase
    end
    // R3: straddling 0x40 pattern (0x04 then 0x00)
    for (int k = 0; k < 256; k++) send_char((k % 2 == 0) ? 8'h04 : 8'h00);
    // R6: only the first and last characters match
    for (int k = 0; k < 256; k++) send_char((k == 0 || k == 255) ? 8'h40 : 8'h00);
    // R2 R5: random mixes
    for (int k = 0; k < 256; k++) send_char(rand_char(25));
    for (int k = 0; k < 256; k++) send_char(rand_char(60));
    // R1: reset in mid-block realigns framing and clears counts
    for (int k = 0; k < 100; k++) send_char(rand_char(30));
    rst_n = 1'b0;
    @(negedge clk);
    check(block_count == 9'd0 && block_done == 1'b0, "R1 mid-block reset", block_count, 0);
    sent = 0; tally_m = 0; exp_count = 0;
    rst_n = 1'b1;
    for (int k = 0; k < 256; k++) send_char(rand_char(40));
    for (int k = 0; k < 256; k++) send_char((k == 255) ? 8'h40 : rand_char(10));
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule